// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit serves a 32-bit core. It handles two bit-field instructions that carry their field description in immediates. The issue stage gives it three things with an input strobe: the instruction word, the value of the source register, and the current value of the destination register.

The unit checks whether the word belongs to it and decodes the field start and field extent. It then computes the new destination value and presents it one cycle later, together with the destination register index and an illegal-field flag.

The two operations encode the field extent differently:

- **Extract** holds the field width directly.
- **Insert** holds the position of the field's top bit. The decoder rebuilds the insert width from that top bit and the start offset.

A word that belongs to neither operation produces no result. Instead it raises a not-mine indication, so that a neighbouring unit can claim the word.

Top module: `bfu_unit`

## Requirements
- R1: An instruction word matches the unit only when `(instr & 32'hFC00C000)` is `32'h64004000` (extract, bit 14 set) or `32'h64008000` (insert, bit 15 set). The bits outside that mask (25:16, 13:11, 10:0 apart from their field meaning) never affect the match.
- R2: For extract, the width is `instr[10:6]` and the start offset is `instr[4:0]`. The result holds source bits `[start + width - 1 : start]` right-justified, and every higher bit is zero.
- R3: For insert, `instr[10:6]` is the top bit position and `instr[4:0]` is the start offset. Destination bits from the start to the top bit take source bits `[top - start : 0]`. All other bits keep the destination input value.
- R4: An extract with width 0, or with width + start greater than 32, sets the illegal flag, and the result equals the destination input.
- R5: An insert whose top bit position is below its start offset sets the illegal flag, and the result equals the destination input. A field reaching bit 31, up to the full 32 bits, is legal.
- R6: A matching word accepted with `in_valid` high gives `out_valid` high on the following cycle. That cycle also carries the result and `out_rd` = `instr[25:21]`. Without an accepted word, `out_valid` is low.
- R7: A word accepted with `in_valid` high that does not match gives `out_not_mine` high and `out_valid` low on the following cycle. The two outputs are never high together.
- R8: While the synchronous active-high `rst` is high at a clock edge, `out_valid` and `out_not_mine` are low after that edge, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction word are presented this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Source register value |
| dst_val | input | 32 | Current destination register value |
| out_valid | output | 1 | Result strobe, one cycle after acceptance |
| out_rd | output | 5 | Destination register index |
| out_result | output | 32 | New destination value |
| out_illegal | output | 1 | Field description was out of range; result is the old destination |
| out_not_mine | output | 1 | Accepted word did not match either operation |

## Verification
The hardest region to reach from the ports is the legal/illegal boundary of the insert form. There, an offset by one in rebuilding the width from the top bit either drops bit 31 or flags a field that is in fact legal.

The stimulus walks every start offset against every top position from the start up to 31. This includes the single 32-bit field. It also walks every extract width/start pair up to the sum of 32, then steps one past each boundary.

Every word carries pseudo-random don't-care bits and pseudo-random operands, so the reference model sees field contents that a fixed pattern would mask.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int XLEN   = 32;
    localparam int SHW    = $clog2(XLEN);
    localparam int CNTW   = SHW + 1;
    localparam int RIDX_W = 5;

    localparam int RD_LO    = 21;
    localparam int FLD_A_LO = 6;
    localparam int FLD_B_LO = 0;

    localparam logic [31:0] OPC_MASK = 32'hFC00C000;
    localparam logic [31:0] OPC_EXT  = 32'h64004000;
    localparam logic [31:0] OPC_INS  = 32'h64008000;

    typedef enum logic [1:0] {
        BF_NONE = 2'd0,
        BF_EXT  = 2'd1,
        BF_INS  = 2'd2
    } bf_op_e;

    typedef struct packed {
        bf_op_e            op;
        logic [RIDX_W-1:0] rd;
        logic [SHW-1:0]    start;
        logic [SHW-1:0]    extent;
    } bf_dec_t;

    typedef struct packed {
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   data;
        logic              illegal;
    } bf_res_t;

    function automatic logic [XLEN-1:0] low_ones(input logic [CNTW-1:0] n);
        logic [XLEN-1:0] m;
        if (n == '0) m = '0;
        else         m = {XLEN{1'b1}} >> (CNTW'(XLEN) - n);
        return m;
    endfunction

endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
    import bfu_pkg::*;
(
    input  logic [31:0] instr,
    output bf_dec_t     dec
);
    logic is_ext;
    logic is_ins;

    always_comb begin
        is_ext = (instr & OPC_MASK) == OPC_EXT;
        is_ins = (instr & OPC_MASK) == OPC_INS;
        if (is_ext)      dec.op = BF_EXT;
        else if (is_ins) dec.op = BF_INS;
        else             dec.op = BF_NONE;
        dec.rd     = instr[RD_LO +: RIDX_W];
        dec.start  = instr[FLD_B_LO +: SHW];
        dec.extent = instr[FLD_A_LO +: SHW];
    end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract
    import bfu_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [SHW-1:0]  start,
    input  logic [SHW-1:0]  width,
    output logic [XLEN-1:0] field,
    output logic            bad
);
    logic [CNTW-1:0] span;

    always_comb begin
        span  = {1'b0, width} + {1'b0, start};
        bad   = (width == '0) || (span > CNTW'(XLEN));
        field = (src >> start) & low_ones({1'b0, width});
    end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert
    import bfu_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    input  logic [SHW-1:0]  start,
    input  logic [SHW-1:0]  top,
    output logic [XLEN-1:0] merged,
    output logic            bad
);
    logic [CNTW-1:0] width;
    logic [XLEN-1:0] mask;

    always_comb begin
        bad    = top < start;
        width  = {1'b0, top} - {1'b0, start} + CNTW'(1);
        mask   = low_ones(width) << start;
        merged = (dst & ~mask) | ((src << start) & mask);
    end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
    import bfu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] src_val,
    input  logic [31:0] dst_val,
    output logic        out_valid,
    output logic [4:0]  out_rd,
    output logic [31:0] out_result,
    output logic        out_illegal,
    output logic        out_not_mine
);
    bf_dec_t         dec;
    logic [XLEN-1:0] ext_field;
    logic            ext_bad;
    logic [XLEN-1:0] ins_merged;
    logic            ins_bad;
    bf_res_t         nxt;
    bf_res_t         res_q;
    logic            vld_q;
    logic            nm_q;

    bfu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bfu_extract u_ext (
        .src   (src_val),
        .start (dec.start),
        .width (dec.extent),
        .field (ext_field),
        .bad   (ext_bad)
    );

    bfu_insert u_ins (
        .src    (src_val),
        .dst    (dst_val),
        .start  (dec.start),
        .top    (dec.extent),
        .merged (ins_merged),
        .bad    (ins_bad)
    );

    always_comb begin
        nxt.rd = dec.rd;
        unique case (dec.op)
            BF_EXT: begin
                nxt.illegal = ext_bad;
                nxt.data    = ext_bad ? dst_val : ext_field;
            end
            BF_INS: begin
                nxt.illegal = ins_bad;
                nxt.data    = ins_bad ? dst_val : ins_merged;
            end
            default: begin
                nxt.illegal = 1'b0;
                nxt.data    = dst_val;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            nm_q  <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid && (dec.op != BF_NONE);
            nm_q  <= in_valid && (dec.op == BF_NONE);
            if (in_valid && (dec.op != BF_NONE)) res_q <= nxt;
        end
    end

    assign out_valid    = vld_q;
    assign out_not_mine = nm_q;
    assign out_rd       = res_q.rd;
    assign out_result   = res_q.data;
    assign out_illegal  = res_q.illegal;
endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] dst_val,
    input logic        out_valid,
    input logic [4:0]  out_rd,
    input logic [31:0] out_result,
    input logic        out_illegal,
    input logic        out_not_mine
);
    logic hit_ext;
    logic hit_ins;
    assign hit_ext = (instr & 32'hFC00C000) == 32'h64004000;
    assign hit_ins = (instr & 32'hFC00C000) == 32'h64008000;

    // R6: accepted matching word yields a strobe and index next cycle
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid && (hit_ext || hit_ins) |=> out_valid && out_rd == $past(instr[25:21]));

    // R6: no strobe without an accepted word
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_not_mine);

    // R7: foreign word reported as not-mine
    a_r7_not_mine: assert property (@(posedge clk) disable iff (rst)
        in_valid && !hit_ext && !hit_ins |=> out_not_mine && !out_valid);

    // R7: strobes are exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_not_mine));

    // R4/R5: illegal field leaves the destination untouched
    a_r4_illegal_passthru: assert property (@(posedge clk) disable iff (rst)
        in_valid && (hit_ext || hit_ins) |=> !out_illegal || out_result == $past(dst_val));

    // R5: insert with top below start is flagged
    a_r5_ins_illegal: assert property (@(posedge clk) disable iff (rst)
        in_valid && hit_ins && (instr[10:6] < instr[4:0]) |=> out_illegal);

    // R8: reset clears the strobes
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> !out_valid && !out_not_mine);
endmodule

bind bfu_unit bfu_unit_chk i_chk (.*);

// File: tb/test_bfu_unit.sv
module test_bfu_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_val = '0;
    logic [31:0] dst_val = '0;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic [31:0] out_result;
    logic        out_illegal;
    logic        out_not_mine;

    bfu_unit i_bfu_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .dst_val(dst_val), .out_valid(out_valid),
        .out_rd(out_rd), .out_result(out_result), .out_illegal(out_illegal),
        .out_not_mine(out_not_mine)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int          due;
        logic        nm;
        logic [4:0]  rd;
        logic [31:0] data;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [31:0] rng = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] nxt_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Reference: bit-by-bit field copy
    function automatic logic [31:0] ref_ext(input logic [31:0] s, input int w, input int st);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = s[st + i];
        return r;
    endfunction

    function automatic logic [31:0] ref_ins(input logic [31:0] s, input logic [31:0] d,
                                            input int st, input int tp);
        logic [31:0] r = d;
        for (int i = st; i <= tp; i++) r[i] = s[i - st];
        return r;
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] s,
                         input logic [31:0] d, input string tag);
        exp_t e;
        int   a;
        int   b;
        @(negedge clk);
        instr = w; src_val = s; dst_val = d; in_valid = 1'b1;
        a = int'(w[10:6]);
        b = int'(w[4:0]);
        e.due = cyc + 1; e.tag = tag; e.rd = w[25:21];
        if ((w & 32'hFC00C000) == 32'h64004000) begin
            e.nm = 0;
            e.bad = (a == 0) || (a + b > 32);
            e.data = e.bad ? d : ref_ext(s, a, b);
        end else if ((w & 32'hFC00C000) == 32'h64008000) begin
            e.nm = 0;
            e.bad = a < b;
            e.data = e.bad ? d : ref_ins(s, d, b, a);
        end else begin
            e.nm = 1; e.bad = 0; e.data = '0;
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic [31:0] base, input int rd,
                                       input int a, input int b);
        logic [31:0] w;
        rng = nxt_rng(rng);
        w = base | (rng & 32'h001F_3820);
        w[25:21] = rd[4:0];
        w[10:6]  = a[4:0];
        w[4:0]   = b[4:0];
        return w;
    endfunction

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (e.nm) begin
                    if (!(out_not_mine && !out_valid)) begin
                        n_fail++;
                        $display("FAIL %s: nm=%0b vld=%0b expected nm=1 vld=0",
                                 e.tag, out_not_mine, out_valid);
                    end
                end else if (!(out_valid && !out_not_mine && out_rd == e.rd &&
                               out_result == e.data && out_illegal == e.bad)) begin
                    n_fail++;
                    $display("FAIL %s: vld=%0b rd=%0d res=%h ill=%0b expected vld=1 rd=%0d res=%h ill=%0b",
                             e.tag, out_valid, out_rd, out_result, out_illegal,
                             e.rd, e.data, e.bad);
                end
            end else if (out_valid || out_not_mine) begin
                n_checks++;
                n_fail++;
                $display("FAIL R6: vld=%0b nm=%0b expected both 0 with nothing issued",
                         out_valid, out_not_mine);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        n_checks++;
        if (out_valid || out_not_mine) begin
            n_fail++;
            $display("FAIL R8: vld=%0b nm=%0b expected 0 0", out_valid, out_not_mine);
        end
        rst = 1'b0;
        idle();

        // R2 and R4: all extract width/start pairs, plus one past the edge
        for (int st = 0; st < 32; st++) begin
            for (int w = 1; w <= 32 - st && w < 32; w++) begin
                rng = nxt_rng(rng);
                issue(mk(32'h64004000, st, w, st), rng, ~rng, "R2");
            end
            if (st > 0) issue(mk(32'h64004000, 3, 33 - st, st), rng ^ 32'hA5A5A5A5, 32'h0BAD_F00D, "R4");
            issue(mk(32'h64004000, 4, 0, st), rng, 32'hCAFE_0000 + st, "R4");
        end

        // R3 and R5: all insert start/top pairs, plus top below start
        for (int st = 0; st < 32; st++) begin
            for (int tp = st; tp < 32; tp++) begin
                rng = nxt_rng(rng);
                issue(mk(32'h64008000, tp, tp, st), rng, nxt_rng(rng), "R3");
            end
            if (st > 0) issue(mk(32'h64008000, 7, st - 1, st), rng, 32'h5555_AAAA, "R5");
        end
        // R5: full 32-bit field, and a field touching bit 31
        issue(32'h6400_87C0 | (5 << 21), 32'hDEAD_BEEF, 32'h0, "R5");
        issue(32'h6400_87DF | (6 << 21), 32'h0000_0001, 32'h1234_5678, "R5");

        // R1: don't-care bits set still decode; foreign words rejected (R7)
        issue(32'h67FF_7FFF & ~32'h0000_8000 | 32'h0000_4000, 32'hFFFF_FFFF, 32'h0, "R1");
        issue(32'h6400_0000, 32'h1, 32'h2, "R7");
        issue(32'h6400_C0C1, 32'h1, 32'h2, "R1");
        issue(32'h6800_4041, 32'h1, 32'h2, "R1");
        issue(32'hE400_8041, 32'h1, 32'h2, "R7");
        idle();
        // R6: gap cycles produce nothing
        repeat (3) idle();

        // R8: reset wins over an accepted word
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; instr = 32'h6400_4041;
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        if (out_valid || out_not_mine) begin
            n_fail++;
            $display("FAIL R8: vld=%0b nm=%0b expected 0 0 under reset", out_valid, out_not_mine);
        end
        rst = 1'b0;
        repeat (2) idle();

        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R6: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule